// File: doc/BRIEF.md
# Latched-Address One-Time-Programmable Memory

This block models a one-time-programmable read-only store of 8192 bytes for a processor that shares its address and data lines on one bus. A cycle opens when the active-low chip select is sampled low on a clock edge. At that edge the block captures the 13-bit address into its own latch, so the bus master can then reuse the lines for data. The latched address stays put until the chip select is released.

Inside, the storage is a square matrix of 256 rows by 256 fuse columns. The upper eight address bits pick a row. The lower five bits pick one column out of each of the eight 32-column groups, and group j supplies data bit j. Every cell starts at 0. A programming cycle, with the program-enable input held high, ORs the input byte into the captured word, so a cell can be blown to 1 but never restored to 0.

Read data goes onto the data port one clock after the address capture. It is driven only while the chip select and the output enable are both low and programming is off. The three-state data port is modelled as a data output plus a separate drive-enable output.

Top module: `otp_latched_rom`

## Requirements
- R1: While reset is held and on the first cycle after it, the drive-enable output `dq_oe` is 0.
- R2: A word that has never been programmed reads as 8'h00.
- R3: With `ce_n`=0, `oe_n`=0 and `prog_en`=0, one clock after the address capture `dq_oe`=1 and `dq_out` carries the stored word.
- R4: With `ce_n`=0 and `oe_n`=1, `dq_oe` is 0.
- R5: With `ce_n`=1, `dq_oe` is 0 whatever the level of `oe_n`.
- R6: The address is captured at the first rising clock edge at which `ce_n` is sampled 0. Later changes on `addr_in` have no effect on the word read until `ce_n` has been sampled 1.
- R7: On the cycle just after the capture edge, `dq_oe` is still 0.
- R8: While a cycle is open with `prog_en`=1, each clock edge after the capture edge sets the captured word to `old | din`.
- R9: A 0 in `din` leaves the matching stored bit unchanged, so a bit at 1 can never return to 0.
- R10: While `prog_en`=1, `dq_oe` is 0.
- R11: Address bits [12:5] select the row and bits [4:0] select the column. Programming one address leaves its neighbours in the same row unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | 13 | Address, sampled when a cycle opens |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| prog_en | input | 1 | Programming enable, high to blow fuses |
| din | input | 8 | Byte whose 1 bits are programmed |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Data port drive enable (0 means high-impedance) |

## Verification
The bench builds the block with its default parameters: 8 row-address bits, 5 column-address bits and 8 data bits. That gives the full 256-by-256 matrix, so the lowest and highest addresses (13'h0000 and 13'h1FFF) are both reachable. It also lets the bench program two addresses that differ only in their column bits and show that they share a row without disturbing each other. Each read scrambles the address bus after the capture edge, which shows that the latch rather than the live bus decides the data.

// File: rtl/otp_pkg.sv
// Package: shared geometry of the fuse matrix.
// Assumes square-ish layout: row length is DATA_W groups of 2**COL_W cells.
package otp_pkg;
    localparam int ROW_BITS  = 8;
    localparam int COL_BITS  = 5;
    localparam int WORD_BITS = 8;
endpackage

// File: rtl/otp_addr_latch.sv
// Address capture: opens a cycle on the first edge chip select is seen low,
// holds the address until chip select is seen high.
// Assumes ce_n is synchronous to clk.
module otp_addr_latch #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              act,
    output logic [ADDR_W-1:0] lat_addr
);
    // Track whether a cycle is open and capture the address when it opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= 1'b0;
            lat_addr <= '0;
        end else if (ce_n) begin
            act <= 1'b0;
        end else if (!act) begin
            act      <= 1'b1;
            lat_addr <= addr_in;
        end
    end

    // R6
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !ce_n) |=> (lat_addr == $past(addr_in)));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !ce_n) |=> $stable(lat_addr));
    // R5
    close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !act);
endmodule

// File: rtl/otp_fuse_matrix.sv
// Fuse matrix: rows of DATA_W*2**COL_W one-way cells; a row decoder picks a
// row, a column decoder picks one cell of each group for each data bit.
// Assumes cells start at 0; writes only ever OR new ones in.
module otp_fuse_matrix #(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ROW_W+COL_W-1:0]  addr,
    input  logic [DATA_W-1:0]       din,
    output logic [DATA_W-1:0]       rd_data
);
    localparam int ROWS    = 1 << ROW_W;
    localparam int COLS    = 1 << COL_W;
    localparam int ROW_LEN = DATA_W * COLS;

    logic [ROW_LEN-1:0] mat [ROWS] = '{default: '0};
    logic [ROW_W-1:0]   row;
    logic [COL_W-1:0]   col;
    logic [ROW_LEN-1:0] sel_row;
    logic [ROW_LEN-1:0] mask;
    logic [DATA_W-1:0]  word;

    assign row     = addr[ROW_W+COL_W-1:COL_W];
    assign col     = addr[COL_W-1:0];
    assign sel_row = mat[row];

    // Spread the input byte onto the selected column of each group.
    always_comb begin
        mask = '0;
        for (int j = 0; j < DATA_W; j++)
            mask[j*COLS + int'(col)] = din[j];
    end

    // Column decoder: one cell per group forms the output word.
    for (genvar j = 0; j < DATA_W; j++) begin : g_col
        assign word[j] = sel_row[j*COLS + int'(col)];
    end

    // Blow fuses: OR the mask into the addressed row.
    always_ff @(posedge clk) begin
        if (we)
            mat[row] <= sel_row | mask;
    end

    // Register the decoded word.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= word;
    end

    // R8
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mat[$past(row)] & $past(mask)) == $past(mask)));
    // R9
    no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mat[$past(row)] & $past(sel_row)) == $past(sel_row)));
endmodule

// File: rtl/otp_out_ctrl.sv
// Output control: marks data valid one clock after capture and gates the
// data port drive with chip select, output enable and programming enable.
// Assumes rd_data is registered from the latched address.
module otp_out_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              prog_en,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic valid;

    // Data valid follows the open cycle by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= act && !ce_n;
    end

    // Gate the drive with the enables.
    always_comb begin
        dq_oe  = valid && !ce_n && !oe_n && !prog_en;
        dq_out = dq_oe ? rd_data : '0;
    end

    // R7
    late_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(act));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !valid);
endmodule

// File: rtl/otp_latched_rom.sv
// Top: one-time-programmable byte store with an address latch.
// Assumes prog_en stays low during reads; a write happens on every edge of an
// open cycle with prog_en high (idempotent, since it ORs).
module otp_latched_rom #(
    parameter int ROW_W  = otp_pkg::ROW_BITS,
    parameter int COL_W  = otp_pkg::COL_BITS,
    parameter int DATA_W = otp_pkg::WORD_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ROW_W+COL_W-1:0] addr_in,
    input  logic                   ce_n,
    input  logic                   oe_n,
    input  logic                   prog_en,
    input  logic [DATA_W-1:0]      din,
    output logic [DATA_W-1:0]      dq_out,
    output logic                   dq_oe
);
    localparam int ADDR_W = ROW_W + COL_W;

    logic              act;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] rd_data;
    logic              we;

    assign we = act && !ce_n && prog_en;

    otp_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr_in(addr_in),
        .act(act), .lat_addr(lat_addr)
    );

    otp_fuse_matrix #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_mat (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(lat_addr), .din(din),
        .rd_data(rd_data)
    );

    otp_out_ctrl #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .act(act), .ce_n(ce_n), .oe_n(oe_n),
        .prog_en(prog_en), .rd_data(rd_data), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // R10
    prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> !dq_oe);
    // R5
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dq_oe);
endmodule

// File: tb/tb_otp_latched_rom.sv
module tb_otp_latched_rom;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr_in = '0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        prog_en = 1'b0;
    logic [7:0]  din = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    otp_latched_rom dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ce_n(ce_n),
        .oe_n(oe_n), .prog_en(prog_en), .din(din),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // {address, program byte, expected word afterwards}
    localparam logic [28:0] VEC [8] = '{
        {13'h0000, 8'h01, 8'h01},
        {13'h1FFF, 8'h80, 8'h80},
        {13'h0000, 8'h10, 8'h11},
        {13'h0000, 8'h00, 8'h11},
        {13'h0021, 8'hFF, 8'hFF},
        {13'h0020, 8'h0F, 8'h0F},
        {13'h1FFF, 8'h7F, 8'hFF},
        {13'h0AAA, 8'h55, 8'h55}
    };

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got oe/data %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Release chip select for one edge so the next cycle can open.
    task automatic close_cycle();
        ce_n = 1'b1; prog_en = 1'b0; oe_n = 1'b1;
        tick();
    endtask

    task automatic program_word(input logic [12:0] a, input logic [7:0] d);
        addr_in = a; din = d; prog_en = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        tick();
        tick();
        chk("R10", {dq_oe, 8'h00}, 9'h000);
        close_cycle();
    endtask

    task automatic read_word(input logic [12:0] a, input logic [7:0] exp, input string req);
        addr_in = a; oe_n = 1'b0; ce_n = 1'b0; prog_en = 1'b0;
        tick();
        chk("R7", {dq_oe, 8'h00}, 9'h000);
        addr_in = a ^ 13'h1555;          // R6: bus reused after capture
        tick();
        chk(req, {dq_oe, dq_out}, {1'b1, exp});
        close_cycle();
    endtask

    initial begin
        tick();
        chk("R1", {dq_oe, 8'h00}, 9'h000);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1", {dq_oe, 8'h00}, 9'h000);

        read_word(13'h1234, 8'h00, "R2");
        read_word(13'h1FFF, 8'h00, "R2");

        for (int i = 0; i < 8; i++) begin
            program_word(VEC[i][28:16], VEC[i][15:8]);
            read_word(VEC[i][28:16], VEC[i][7:0], "R8/R9/R3/R6");
        end

        // R11: neighbours in the same row keep their own contents
        read_word(13'h0021, 8'hFF, "R11");
        read_word(13'h0020, 8'h0F, "R11");
        read_word(13'h0022, 8'h00, "R11");

        // R4: outputs off while oe_n high
        addr_in = 13'h0021; oe_n = 1'b1; ce_n = 1'b0;
        tick(); tick();
        chk("R4", {dq_oe, 8'h00}, 9'h000);
        oe_n = 1'b0;
        tick();
        chk("R3", {dq_oe, dq_out}, 9'h1FF);
        // R5: deselect with oe_n low
        ce_n = 1'b1;
        #1;
        chk("R5", {dq_oe, 8'h00}, 9'h000);
        tick();
        chk("R5", {dq_oe, 8'h00}, 9'h000);
        close_cycle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule